// File: doc/BRIEF.md
# Stereo Butterfly Volume Attenuator

This block scales a stereo sample stream through four independent attenuators arranged as a butterfly. Each output channel is the sum of two contributions: one from the left input and one from the right input. Each contribution passes through its own attenuator. Every attenuator has an 8-bit setting in whole decibels. With one setup the block acts as a volume control, with another as a balance control, and with another as a mono down-mix.

Each decibel setting is split into a 6 dB part and a remainder. The 6 dB part becomes an arithmetic right shift. The remainder selects one of six fixed-point gain mantissas covering 0 to 5 dB. Any setting of 96 dB or more silences its path exactly. The two contributions to each output are added at full precision and then clamped to the sample width.

The four settings sit in registers that load together on a write strobe. After reset these registers hold a plain stereo pass-through. Samples move through a fixed three-stage pipeline, and the valid strobe is delayed to match.

Top module: `bfly_atten`

## Requirements
- R1: While reset is high and on the first cycle after it, `out_valid`, `out_left` and `out_right` are all zero.
- R2: A sample accepted with `in_valid` high at a rising edge appears on the outputs, with `out_valid` high, after exactly three rising edges. `out_valid` is low in the two cycles before that.
- R3: `out_left` is the sum of the left input through the left-to-left path and the right input through the right-to-left path. `out_right` is the sum of the left input through the left-to-right path and the right input through the right-to-right path.
- R4: For a setting a below 96, a path gives floor(x * M[a mod 6] / 2^(15 + a div 6)). The mantissa table is M = {32768, 29205, 26029, 23198, 20675, 18427}, one entry per dB from 0 to 5, and each entry is within 0.1 dB of the ideal.
- R5: A setting of 96 or more, including 255, makes that path contribute exactly zero, even for negative samples. At 95, a sample of -1 still gives -1.
- R6: A setting of 0 passes the sample through that path unchanged, including the most negative value.
- R7: When the two contributions to an output add up beyond the signed output range, the output clamps to the largest positive value or the most negative value.
- R8: The setting registers reset to left-to-left 0, right-to-left 255, left-to-right 255 and right-to-right 0, so that after reset the block passes both channels straight through.
- R9: The setting registers load all four attenuation inputs at a rising edge where `att_we` is high. A sample accepted at the next edge or later uses the new values. Changes on the attenuation inputs while `att_we` is low have no effect on the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input sample pair valid |
| in_left | input | DATA_W | Signed left input sample |
| in_right | input | DATA_W | Signed right input sample |
| att_we | input | 1 | Loads the four attenuation settings |
| att_ll | input | ATT_W | Left-to-left attenuation, dB |
| att_rl | input | ATT_W | Right-to-left attenuation, dB |
| att_lr | input | ATT_W | Left-to-right attenuation, dB |
| att_rr | input | ATT_W | Right-to-right attenuation, dB |
| out_valid | output | 1 | Output sample pair valid |
| out_left | output | DATA_W | Signed left output sample |
| out_right | output | DATA_W | Signed right output sample |

## Verification
The bench builds the block with its defaults: 16-bit samples and 8-bit settings. The 8-bit settings reach the whole range from 0 to 255, including the 95/96 boundary where a path turns to exact silence. Two full-scale 16-bit inputs on a pair of 0 dB paths are enough to drive each output into both clamps. The directed scenarios cover each mantissa entry, shifts up to the largest, the reset defaults, and setting changes made without the write strobe.

// File: rtl/bfly_att_pkg.sv
package bfly_att_pkg;
  // one arithmetic shift step equals this many dB
  localparam int STEP_DB = 6;
  // fractional bits of the gain mantissa (0 dB == 1 << FRAC_SH)
  localparam int FRAC_SH = 15;
  // mantissa width, unsigned
  localparam int MANT_W  = 16;
  // number of shift steps before a path is forced silent (16 * 6 = 96 dB)
  localparam int SH_STEPS = 16;
  localparam int SH_W    = $clog2(SH_STEPS);
  // number of attenuation paths in the butterfly
  localparam int NPATH   = 4;
endpackage

// File: rtl/att_decode.sv
module att_decode
  import bfly_att_pkg::*;
#(
  parameter int ATT_W = 8
) (
  input  logic [ATT_W-1:0]  att,
  output logic [MANT_W-1:0] mant,
  output logic [SH_W-1:0]   shift,
  output logic              silent
);
  localparam logic [ATT_W-1:0] STEP = ATT_W'(STEP_DB);

  logic [ATT_W-1:0] quo;
  logic [ATT_W-1:0] rem;

  always_comb begin
    quo    = att / STEP;
    rem    = att - quo * STEP;
    shift  = quo[SH_W-1:0];
    silent = |quo[ATT_W-1:SH_W];
    case (rem)
      ATT_W'(0): mant = 16'd32768;
      ATT_W'(1): mant = 16'd29205;
      ATT_W'(2): mant = 16'd26029;
      ATT_W'(3): mant = 16'd23198;
      ATT_W'(4): mant = 16'd20675;
      default:   mant = 16'd18427;
    endcase
  end
endmodule

// File: rtl/att_path.sv
module att_path
  import bfly_att_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ATT_W  = 8
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic signed [DATA_W-1:0] samp,
  input  logic [ATT_W-1:0]         att,
  output logic signed [DATA_W-1:0] res
);
  localparam int PROD_W = DATA_W + MANT_W + 1;

  logic [MANT_W-1:0]        mant_d;
  logic [SH_W-1:0]          shift_d;
  logic                     silent_d;

  logic signed [DATA_W-1:0] samp_q;
  logic [MANT_W-1:0]        mant_q;
  logic [SH_W-1:0]          shift_q;
  logic                     silent_q;

  logic signed [PROD_W-1:0] prod;
  logic signed [PROD_W-1:0] scaled;

  att_decode #(.ATT_W(ATT_W)) u_dec (
    .att    (att),
    .mant   (mant_d),
    .shift  (shift_d),
    .silent (silent_d)
  );

  // stage 1: capture sample and decoded gain
  always_ff @(posedge clk) begin
    if (rst) begin
      samp_q   <= '0;
      mant_q   <= '0;
      shift_q  <= '0;
      silent_q <= 1'b1;
    end else begin
      samp_q   <= samp;
      mant_q   <= mant_d;
      shift_q  <= shift_d;
      silent_q <= silent_d;
    end
  end

  always_comb begin
    prod   = samp_q * $signed({1'b0, mant_q});
    scaled = prod >>> (FRAC_SH + int'(shift_q));
  end

  // stage 2: scaled result
  always_ff @(posedge clk) begin
    if (rst)           res <= '0;
    else if (silent_q) res <= '0;
    else               res <= scaled[DATA_W-1:0];
  end

  // R5: a silent path yields exact zero
  a_r5_silent_zero: assert property (@(posedge clk) disable iff (rst)
    silent_q |=> (res == '0));

  // R4: gain never exceeds unity, so the scaled value fits the sample width
  a_r4_fits: assert property (@(posedge clk) disable iff (rst)
    (scaled[PROD_W-1:DATA_W-1] == '0) || (scaled[PROD_W-1:DATA_W-1] == '1));

  // R6: zero dB on stage 1 leaves the sample unchanged one cycle later
  a_r6_unity: assert property (@(posedge clk) disable iff (rst)
    (!silent_q && mant_q == 16'd32768 && shift_q == '0) |=> (res == $past(samp_q)));
endmodule

// File: rtl/mix_sat.sv
module mix_sat #(
  parameter int DATA_W = 16
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic signed [DATA_W-1:0] a,
  input  logic signed [DATA_W-1:0] b,
  output logic signed [DATA_W-1:0] y
);
  localparam int SUM_W = DATA_W + 1;
  localparam logic signed [DATA_W-1:0] POS_MAX = {1'b0, {(DATA_W-1){1'b1}}};
  localparam logic signed [DATA_W-1:0] NEG_MAX = {1'b1, {(DATA_W-1){1'b0}}};

  logic signed [SUM_W-1:0] sum;
  logic                    over_pos;
  logic                    over_neg;

  always_comb begin
    sum      = SUM_W'(a) + SUM_W'(b);
    over_pos = (sum[SUM_W-1:SUM_W-2] == 2'b01);
    over_neg = (sum[SUM_W-1:SUM_W-2] == 2'b10);
  end

  always_ff @(posedge clk) begin
    if (rst)           y <= '0;
    else if (over_pos) y <= POS_MAX;
    else if (over_neg) y <= NEG_MAX;
    else               y <= sum[DATA_W-1:0];
  end

  // R7: positive overflow clamps to the largest value
  a_r7_clamp_pos: assert property (@(posedge clk) disable iff (rst)
    (!a[DATA_W-1] && !b[DATA_W-1] && sum[DATA_W-1]) |=> (y == POS_MAX));

  // R7: negative overflow clamps to the most negative value
  a_r7_clamp_neg: assert property (@(posedge clk) disable iff (rst)
    (a[DATA_W-1] && b[DATA_W-1] && !sum[DATA_W-1]) |=> (y == NEG_MAX));
endmodule

// File: rtl/bfly_atten.sv
module bfly_atten
  import bfly_att_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ATT_W  = 8
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     in_valid,
  input  logic signed [DATA_W-1:0] in_left,
  input  logic signed [DATA_W-1:0] in_right,
  input  logic                     att_we,
  input  logic [ATT_W-1:0]         att_ll,
  input  logic [ATT_W-1:0]         att_rl,
  input  logic [ATT_W-1:0]         att_lr,
  input  logic [ATT_W-1:0]         att_rr,
  output logic                     out_valid,
  output logic signed [DATA_W-1:0] out_left,
  output logic signed [DATA_W-1:0] out_right
);
  // two stages in each path, one in the mixer
  localparam int PATH_LAT = 2;
  localparam int LAT      = PATH_LAT + 1;

  // path order: 0 L->L, 1 R->L, 2 L->R, 3 R->R
  logic [ATT_W-1:0]         att_in  [NPATH];
  logic [ATT_W-1:0]         att_q   [NPATH];
  logic signed [DATA_W-1:0] p_in    [NPATH];
  logic signed [DATA_W-1:0] p_out   [NPATH];
  logic [LAT-1:0]           vpipe;

  always_comb begin
    att_in[0] = att_ll;
    att_in[1] = att_rl;
    att_in[2] = att_lr;
    att_in[3] = att_rr;
  end

  for (genvar g = 0; g < NPATH; g++) begin : g_path
    // even paths take the left input, odd paths the right one
    localparam bit FROM_RIGHT = (g % 2) == 1;
    // direct paths reset to 0 dB, cross paths to full attenuation
    localparam bit IS_CROSS   = (g == 1) || (g == 2);
    localparam logic [ATT_W-1:0] RST_VAL = IS_CROSS ? '1 : '0;

    always_ff @(posedge clk) begin
      if (rst)         att_q[g] <= RST_VAL;
      else if (att_we) att_q[g] <= att_in[g];
    end

    if (FROM_RIGHT) begin : g_r
      assign p_in[g] = in_right;
    end else begin : g_l
      assign p_in[g] = in_left;
    end

    att_path #(.DATA_W(DATA_W), .ATT_W(ATT_W)) u_path (
      .clk  (clk),
      .rst  (rst),
      .samp (p_in[g]),
      .att  (att_q[g]),
      .res  (p_out[g])
    );
  end

  mix_sat #(.DATA_W(DATA_W)) u_mix_l (
    .clk (clk), .rst (rst), .a (p_out[0]), .b (p_out[1]), .y (out_left)
  );

  mix_sat #(.DATA_W(DATA_W)) u_mix_r (
    .clk (clk), .rst (rst), .a (p_out[2]), .b (p_out[3]), .y (out_right)
  );

  always_ff @(posedge clk) begin
    if (rst) vpipe <= '0;
    else     vpipe <= {vpipe[LAT-2:0], in_valid};
  end
  assign out_valid = vpipe[LAT-1];

  // R8: defaults present on the first cycle after reset
  a_r8_defaults: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (att_q[0] == '0 && att_q[1] == '1 && att_q[2] == '1 && att_q[3] == '0));

  // R9: settings hold while the write strobe is low
  a_r9_hold: assert property (@(posedge clk) disable iff (rst)
    !att_we |=> $stable(att_q[0]) && $stable(att_q[1]) && $stable(att_q[2]) && $stable(att_q[3]));

  // R2: valid leaves exactly three cycles after it enters
  a_r2_latency: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst, 1) && !$past(rst, 2) && !$past(rst, 3)) |-> (out_valid == $past(in_valid, 3)));

  // R1: outputs are idle right after reset
  a_r1_reset_idle: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!out_valid && out_left == '0 && out_right == '0));
endmodule

// File: tb/bfly_atten_test.sv
module bfly_atten_test;
  localparam int DATA_W = 16;
  localparam int ATT_W  = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic signed [DATA_W-1:0] in_left = '0;
  logic signed [DATA_W-1:0] in_right = '0;
  logic att_we = 1'b0;
  logic [ATT_W-1:0] att_ll = '0, att_rl = '0, att_lr = '0, att_rr = '0;
  logic out_valid;
  logic signed [DATA_W-1:0] out_left, out_right;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  // model settings as the bench believes them to be loaded
  int m_ll = 0, m_rl = 255, m_lr = 255, m_rr = 0;

  always #4 clk = ~clk;

  bfly_atten #(.DATA_W(DATA_W), .ATT_W(ATT_W)) uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_left(in_left), .in_right(in_right),
    .att_we(att_we), .att_ll(att_ll), .att_rl(att_rl), .att_lr(att_lr), .att_rr(att_rr),
    .out_valid(out_valid), .out_left(out_left), .out_right(out_right)
  );

  function automatic longint mant_of(int f);
    case (f)
      0: return 32768;
      1: return 29205;
      2: return 26029;
      3: return 23198;
      4: return 20675;
      default: return 18427;
    endcase
  endfunction

  function automatic longint path_model(longint x, int a);
    longint p;
    if (a >= 96) return 0;
    p = x * mant_of(a % 6);
    return p >>> (15 + a / 6);
  endfunction

  function automatic longint clamp(longint v);
    if (v > 32767) return 32767;
    if (v < -32768) return -32768;
    return v;
  endfunction

  task automatic check(string req, longint act, longint exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic load_att(int a, int b, int c, int d);
    @(negedge clk);
    att_ll = ATT_W'(a); att_rl = ATT_W'(b); att_lr = ATT_W'(c); att_rr = ATT_W'(d);
    att_we = 1'b1;
    @(negedge clk);
    att_we = 1'b0;
    m_ll = a; m_rl = b; m_lr = c; m_rr = d;
  endtask

  // sends one pair and checks latency and both outputs (R2, R3)
  task automatic send(string req, int l, int r);
    longint el, er;
    el = clamp(path_model(l, m_ll) + path_model(r, m_rl));
    er = clamp(path_model(l, m_lr) + path_model(r, m_rr));
    @(negedge clk);
    in_left = DATA_W'(l); in_right = DATA_W'(r); in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check("R2 valid early 1", longint'(out_valid), 0);
    @(negedge clk);
    check("R2 valid early 2", longint'(out_valid), 0);
    @(negedge clk);
    check("R2 valid on time", longint'(out_valid), 1);
    check({req, " left"}, longint'(out_left), el);
    check({req, " right"}, longint'(out_right), er);
  endtask

  task automatic t_reset;
    check("R1 valid in reset", longint'(out_valid), 0);
    check("R1 left in reset", longint'(out_left), 0);
    @(negedge clk);
    rst = 1'b0;
    check("R1 valid after reset", longint'(out_valid), 0);
    check("R1 right after reset", longint'(out_right), 0);
  endtask

  task automatic t_defaults;
    // R8 / R6: straight pass-through, most negative value included
    send("R8 default", 1000, -2000);
    send("R6 unity", -32768, 32767);
  endtask

  task automatic t_steps;
    int steps[9] = '{1, 2, 3, 4, 5, 6, 13, 50, 89};
    foreach (steps[i]) begin
      load_att(steps[i], 255, 255, steps[i]);
      send("R4 step", 12345, -23456);
    end
    load_att(6, 6, 12, 1);
    send("R3 mix", 20000, -15000);
    load_att(0, 255, 0, 0);
    send("R3 mono right", 7000, 9000);
  endtask

  task automatic t_silence;
    load_att(95, 255, 255, 95);
    send("R5 edge 95", -1, -1);
    check("R5 edge 95 negative keeps -1", longint'(out_left), -1);
    load_att(96, 255, 255, 200);
    send("R5 silent", -32768, -1);
    check("R5 exact zero", longint'(out_right), 0);
  endtask

  task automatic t_saturate;
    load_att(0, 0, 0, 0);
    send("R7 pos", 30000, 10000);
    check("R7 pos clamp", longint'(out_left), 32767);
    send("R7 neg", -30000, -10000);
    check("R7 neg clamp", longint'(out_right), -32768);
    send("R7 both min", -32768, -32768);
  endtask

  task automatic t_ignore;
    load_att(3, 255, 255, 9);
    @(negedge clk);
    att_ll = 8'd0; att_rl = 8'd0; att_lr = 8'd0; att_rr = 8'd0;
    // strobe stays low: the model keeps 3/255/255/9
    send("R9 ignored", 4000, -4000);
    load_att(0, 255, 255, 0);
    send("R9 loaded", 4000, -4000);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    t_defaults();
    t_steps();
    t_silence();
    t_saturate();
    t_ignore();
    repeat (4) @(negedge clk);
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    #(8 * 20000);
    if (!done) begin
      done = 1'b1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end
endmodule